// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Sequencer

This block turns single read or write requests from a small 8-bit processor core into external bus cycles over a 16-bit address space. The low address byte and the data byte share one group of pins. In the first clock of a cycle the shared pins carry the low address byte, and a one-clock latch pulse marks them as address. In the following clocks the same pins carry data. The high address byte has its own pins and stays driven for the whole cycle. Every pin group comes with an output-enable signal, so the chip's pad ring can build the tri-state drivers.

The core raises `req_valid` together with the direction, the space (memory or I/O), the address and the write data. It keeps them stable until it sees `req_done`. A slow device can stretch a cycle by holding `bus_ready` low, and each low sample adds one whole clock. Another bus master can ask for the bus with `bus_hold`. The sequencer finishes any transfer in flight, then floats every bus output and answers with `bus_hlda` until the request goes away.

The sequencer has six states. ST_IDLE drives the control lines inactive. ST_T1 drives the address and pulses the latch strobe. ST_T2 asserts the read or write strobe. ST_TW is a wait state. ST_T3 completes the transfer. ST_HELD floats the bus for another master. The transitions are:
- idle→T1 on a request with no hold pending.
- idle→held on hold.
- T1→T2 always.
- T2→T3 and TW→T3 when ready is high.
- T2→TW and TW→TW when ready is low.
- T3→idle when there is no hold.
- T3→held on hold.
- held→idle when hold drops.

Top module: `muxbus_ctrl`

## Requirements
- R1: While `rst_n` is low, `bus_addr_hi_oe`, `bus_ad_oe`, `bus_ctl_oe`, `bus_ale`, `bus_hlda` and `req_done` are all 0.
- R2: In ST_IDLE, `bus_ctl_oe`=1, `bus_rd_n`=`bus_wr_n`=1, `bus_ale`=0, `bus_ad_oe`=0, `bus_addr_hi_oe`=0, `bus_io_m`=0 and `bus_stat`=2'b00.
- R3: When `req_valid` is high and `bus_hold` is low at a clock edge in ST_IDLE, the next cycle is T1. In T1, `bus_ad_out` is address bits [7:0] with `bus_ad_oe`=1, `bus_addr_hi` is bits [15:8] with `bus_addr_hi_oe`=1, and both strobes are high.
- R4: From T1 through T3, `bus_io_m` is 1 for an I/O cycle and 0 for a memory cycle. `bus_stat` is 2'b10 for a read and 2'b01 for a write. Outside a cycle, `bus_stat` is 2'b00.
- R5: In a read, `bus_rd_n` is 0 in T2, in every wait state and in T3, and `bus_ad_oe` is 0 there. `bus_wr_n` stays 1. The two strobes are never low together.
- R6: In a write, `bus_wr_n` is 0 in T2, in every wait state and in T3. During those cycles `bus_ad_oe`=1 and `bus_ad_out` is the write data, so the data is still driven at the clock edge where the strobe rises. `bus_rd_n` stays 1.
- R7: `bus_ready` is sampled at the clock edge that ends T2 and at the edge that ends each wait state. Each low sample adds one wait state with the same outputs as T2. `bus_ready` is ignored in every other state.
- R8: `req_done` is high only in T3, for exactly one cycle per transfer. During a read's T3, `req_rdata` equals `bus_ad_in`; otherwise it is 0.
- R9: If `bus_hold` is high at an edge in ST_IDLE, the next cycle has `bus_hlda`=1 and all three enables at 0. No request is accepted while the bus is held.
- R10: A hold that arrives during a transfer does not shorten it. T3 and `req_done` occur as usual, and `bus_hlda` rises in the cycle after T3.
- R11: `bus_hlda` stays high while `bus_hold` is high. After `bus_hold` is seen low, the next cycle is ST_IDLE, and a pending request's T1 follows one cycle later.
- R12: `bus_ale` is high for exactly one cycle per transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one T-state per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core transfer request, held until done |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory |
| req_addr | input | ADDR_W | Transfer address |
| req_wdata | input | DATA_W | Write data |
| req_done | output | 1 | Completion strobe (T3) |
| req_rdata | output | DATA_W | Read data, valid with done on reads |
| bus_addr_hi | output | ADDR_W-DATA_W | High address byte |
| bus_addr_hi_oe | output | 1 | Enable for the high address pins |
| bus_ad_out | output | DATA_W | Shared address/data lines, outgoing value |
| bus_ad_oe | output | 1 | Enable for the shared lines |
| bus_ad_in | input | DATA_W | Shared lines, incoming value |
| bus_ale | output | 1 | Address latch strobe |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_io_m | output | 1 | 1 = I/O cycle, 0 = memory cycle |
| bus_stat | output | 2 | Operation status: 10 read, 01 write, 00 none |
| bus_ctl_oe | output | 1 | Enable for strobes and status pins |
| bus_ready | input | 1 | Device ready; low inserts wait states |
| bus_hold | input | 1 | External master bus request |
| bus_hlda | output | 1 | Bus released to the external master |

## Verification
Some properties are checked by assertions on every cycle:
- the two strobes are never low together;
- the latch pulse lasts one cycle;
- T1 is entered only from idle on an accepted request;
- wait states are entered only after a low ready sample;
- a held bus floats every enable;
- completion is marked only while a strobe is active.

Other behaviour needs the bench's scenarios, which compare every output against a behavioural model on every clock:
- the exact address and data values on the shared lines;
- how many wait states follow a given number of low ready samples;
- that ready is ignored outside T2 and wait states;
- that a hold raised mid-transfer waits for T3;
- that a request pending during hold starts only after the idle cycle.

// File: rtl/muxbus_pkg.sv
package muxbus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_T1,
        ST_T2,
        ST_TW,
        ST_T3,
        ST_HELD
    } bus_state_t;

    localparam logic [1:0] STAT_NONE  = 2'b00;
    localparam logic [1:0] STAT_WRITE = 2'b01;
    localparam logic [1:0] STAT_READ  = 2'b10;

    typedef struct packed {
        logic write;
        logic io;
    } bus_op_t;

endpackage

// File: rtl/muxbus_fsm.sv
module muxbus_fsm
    import muxbus_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       ready,
    input  logic       hold,
    output bus_state_t state,
    output logic       load_req
);

    bus_state_t state_nx;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        load_req = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (hold) begin
                    state_nx = ST_HELD;
                end else if (req_valid) begin
                    state_nx = ST_T1;
                    load_req = 1'b1;
                end
            end
            ST_T1:   state_nx = ST_T2;
            ST_T2,
            ST_TW:   state_nx = ready ? ST_T3 : ST_TW;
            ST_T3:   state_nx = hold ? ST_HELD : ST_IDLE;
            ST_HELD: state_nx = hold ? ST_HELD : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // T1 follows only an accepted request in idle (R3)
    assert_t1_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_T1) |-> ($past(state) == ST_IDLE && $past(req_valid) && !$past(hold)));

    // A wait state follows only a low ready sample at the end of T2 or a wait state (R7)
    assert_wait_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TW) |-> (!$past(ready) &&
                              ($past(state) == ST_T2 || $past(state) == ST_TW)));

    // A dropped hold returns the sequencer to idle (R11)
    assert_hold_exit_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HELD && !hold) |=> (state == ST_IDLE));

    // Hold never cuts a transfer short (R10)
    assert_hold_after_t3_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_HELD) |-> ($past(state) == ST_IDLE || $past(state) == ST_T3));

endmodule

// File: rtl/muxbus_req_latch.sv
module muxbus_req_latch
    import muxbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic              write_in,
    input  logic              io_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output bus_op_t           op_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            op_q    <= '0;
        end else if (load) begin
            addr_q   <= addr_in;
            wdata_q  <= wdata_in;
            op_q.write <= write_in;
            op_q.io    <= io_in;
        end
    end

endmodule

// File: rtl/muxbus_drive.sv
module muxbus_drive
    import muxbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    localparam int HI_W  = ADDR_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_state_t        state,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [DATA_W-1:0] wdata_q,
    input  bus_op_t           op_q,
    input  logic [DATA_W-1:0] ad_in,
    output logic [HI_W-1:0]   addr_hi,
    output logic              addr_hi_oe,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic              io_m,
    output logic [1:0]        stat,
    output logic              ctl_oe,
    output logic              hlda,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);

    logic in_cycle;
    logic strobing;

    // Output decode
    always_comb begin
        in_cycle   = 1'b0;
        strobing   = 1'b0;
        ale        = 1'b0;
        done       = 1'b0;
        hlda       = 1'b0;
        ctl_oe     = rst_n;
        unique case (state)
            ST_IDLE: ;
            ST_T1: begin
                in_cycle = 1'b1;
                ale      = rst_n;
            end
            ST_T2,
            ST_TW: begin
                in_cycle = 1'b1;
                strobing = 1'b1;
            end
            ST_T3: begin
                in_cycle = 1'b1;
                strobing = 1'b1;
                done     = rst_n;
            end
            ST_HELD: begin
                hlda   = rst_n;
                ctl_oe = 1'b0;
            end
            default: ;
        endcase

        addr_hi    = addr_q[ADDR_W-1:DATA_W];
        addr_hi_oe = rst_n && in_cycle;
        ad_out     = (state == ST_T1) ? addr_q[DATA_W-1:0] : wdata_q;
        ad_oe      = rst_n && ((state == ST_T1) || (strobing && op_q.write));
        rd_n       = !(rst_n && strobing && !op_q.write);
        wr_n       = !(rst_n && strobing && op_q.write);
        io_m       = in_cycle && op_q.io;
        stat       = !in_cycle ? STAT_NONE : (op_q.write ? STAT_WRITE : STAT_READ);
        rdata      = (done && !op_q.write) ? ad_in : '0;
    end

    // Strobes never low together (R5)
    assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    // Latch pulse lasts a single cycle (R12)
    assert_ale_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    // Held bus floats every enable (R9)
    assert_hlda_float_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hlda |-> (!ad_oe && !addr_hi_oe && !ctl_oe));

    // Completion only with an active strobe (R8)
    assert_done_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!rd_n || !wr_n));

    // Outputs released in reset (R1)
    always_comb begin
        if (!rst_n) begin
            assert_reset_float_R1: assert (!ad_oe && !addr_hi_oe && !ctl_oe && !hlda);
        end
    end

endmodule

// File: rtl/muxbus_ctrl.sv
module muxbus_ctrl
    import muxbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    localparam int HI_W  = ADDR_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_io,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_done,
    output logic [DATA_W-1:0] req_rdata,
    output logic [HI_W-1:0]   bus_addr_hi,
    output logic              bus_addr_hi_oe,
    output logic [DATA_W-1:0] bus_ad_out,
    output logic              bus_ad_oe,
    input  logic [DATA_W-1:0] bus_ad_in,
    output logic              bus_ale,
    output logic              bus_rd_n,
    output logic              bus_wr_n,
    output logic              bus_io_m,
    output logic [1:0]        bus_stat,
    output logic              bus_ctl_oe,
    input  logic              bus_ready,
    input  logic              bus_hold,
    output logic              bus_hlda
);

    bus_state_t        state;
    logic              load_req;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    bus_op_t           op_q;

    muxbus_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .ready     (bus_ready),
        .hold      (bus_hold),
        .state     (state),
        .load_req  (load_req)
    );

    muxbus_req_latch #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_req),
        .addr_in  (req_addr),
        .wdata_in (req_wdata),
        .write_in (req_write),
        .io_in    (req_io),
        .addr_q   (addr_q),
        .wdata_q  (wdata_q),
        .op_q     (op_q)
    );

    muxbus_drive #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_drive (
        .clk        (clk),
        .rst_n      (rst_n),
        .state      (state),
        .addr_q     (addr_q),
        .wdata_q    (wdata_q),
        .op_q       (op_q),
        .ad_in      (bus_ad_in),
        .addr_hi    (bus_addr_hi),
        .addr_hi_oe (bus_addr_hi_oe),
        .ad_out     (bus_ad_out),
        .ad_oe      (bus_ad_oe),
        .ale        (bus_ale),
        .rd_n       (bus_rd_n),
        .wr_n       (bus_wr_n),
        .io_m       (bus_io_m),
        .stat       (bus_stat),
        .ctl_oe     (bus_ctl_oe),
        .hlda       (bus_hlda),
        .done       (req_done),
        .rdata      (req_rdata)
    );

endmodule

// File: tb/muxbus_ctrl_test.sv
`timescale 1ns/1ps
module muxbus_ctrl_test;

    localparam int P_IDLE = 0, P_T1 = 1, P_T2 = 2, P_TW = 3, P_T3 = 4, P_HELD = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_io = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_done;
    logic [7:0]  req_rdata;
    logic [7:0]  bus_addr_hi;
    logic        bus_addr_hi_oe;
    logic [7:0]  bus_ad_out;
    logic        bus_ad_oe;
    logic [7:0]  bus_ad_in = '0;
    logic        bus_ale, bus_rd_n, bus_wr_n, bus_io_m, bus_ctl_oe, bus_hlda;
    logic [1:0]  bus_stat;
    logic        bus_ready = 1'b1;
    logic        bus_hold = 1'b0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit run_chk = 0;

    // reference model state
    int          ph = P_IDLE;
    logic        m_w = 0, m_io = 0;
    logic [15:0] m_addr = '0;
    logic [7:0]  m_wd = '0;

    always #2.5 clk = ~clk;

    muxbus_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_io(req_io), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_done(req_done), .req_rdata(req_rdata), .bus_addr_hi(bus_addr_hi),
        .bus_addr_hi_oe(bus_addr_hi_oe), .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe),
        .bus_ad_in(bus_ad_in), .bus_ale(bus_ale), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
        .bus_io_m(bus_io_m), .bus_stat(bus_stat), .bus_ctl_oe(bus_ctl_oe),
        .bus_ready(bus_ready), .bus_hold(bus_hold), .bus_hlda(bus_hlda)
    );

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Behavioural model, advanced on each rising edge
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            ph = P_IDLE;
        end else begin
            case (ph)
                P_IDLE: if (bus_hold) ph = P_HELD;
                        else if (req_valid) begin
                            ph = P_T1; m_w = req_write; m_io = req_io;
                            m_addr = req_addr; m_wd = req_wdata;
                        end
                P_T1:   ph = P_T2;
                P_T2, P_TW: ph = bus_ready ? P_T3 : P_TW;
                P_T3:   ph = bus_hold ? P_HELD : P_IDLE;
                P_HELD: ph = bus_hold ? P_HELD : P_IDLE;
                default: ph = P_IDLE;
            endcase
        end
        if (cyc > 20000) begin
            errors++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            summary();
        end
    end

    // Full comparison on every falling edge
    always @(negedge clk) begin
        if (run_chk && rst_n) begin
            automatic bit inx = (ph >= P_T1 && ph <= P_T3);
            automatic bit stb = (ph >= P_T2 && ph <= P_T3);
            chk("R12/R3 ale", bus_ale, ph == P_T1);
            chk("R5 rd_n", bus_rd_n, !(stb && !m_w));
            chk("R6 wr_n", bus_wr_n, !(stb && m_w));
            chk("R5/R6 ad_oe", bus_ad_oe, (ph == P_T1) || (stb && m_w));
            if (ph == P_T1) chk("R3 ad_out address", bus_ad_out, m_addr[7:0]);
            if (stb && m_w) chk("R6 ad_out data", bus_ad_out, m_wd);
            chk("R2/R3 addr_hi_oe", bus_addr_hi_oe, inx);
            if (inx) chk("R3 addr_hi", bus_addr_hi, m_addr[15:8]);
            chk("R4 io_m", bus_io_m, inx && m_io);
            chk("R4 stat", bus_stat, !inx ? 2'b00 : (m_w ? 2'b01 : 2'b10));
            chk("R8 done", req_done, ph == P_T3);
            chk("R8 rdata", req_rdata, (ph == P_T3 && !m_w) ? bus_ad_in : 8'h00);
            chk("R9/R11 hlda", bus_hlda, ph == P_HELD);
            chk("R2/R9 ctl_oe", bus_ctl_oe, ph != P_HELD);
        end
    end

    // One transfer: hold_cycles>0 means hold is already high and drops after that many cycles
    task automatic xfer(bit w, bit io, logic [15:0] a, logic [7:0] d, int waits,
                        bit hold_mid, int hold_cycles);
        int left = waits;
        int n = 0;
        bit seen = 0;
        req_write = w; req_io = io; req_addr = a; req_wdata = d; req_valid = 1'b1;
        while (!seen) begin
            @(negedge clk); #1;
            n++;
            if (ph == P_T3) seen = 1;
            if (hold_cycles > 0 && n == hold_cycles) bus_hold = 1'b0;
            if (hold_mid && ph == P_T2) bus_hold = 1'b1;
            bus_ad_in = 8'($urandom);
            if (ph == P_T2 || ph == P_TW) begin
                if (left > 0) begin bus_ready = 1'b0; left--; end
                else bus_ready = 1'b1;
            end else begin
                bus_ready = n[0];   // R7: ignored outside T2 and wait states
            end
            if (n > 200) seen = 1;
        end
        req_valid = 1'b0;
    endtask

    task automatic idle(int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk); #1;
            bus_ready = i[0];
        end
    endtask

    initial begin
        // R1: reset floats the bus
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R1 addr_hi_oe", bus_addr_hi_oe, 0);
            chk("R1 ad_oe", bus_ad_oe, 0);
            chk("R1 ctl_oe", bus_ctl_oe, 0);
            chk("R1 hlda/ale/done", {bus_hlda, bus_ale, req_done}, 0);
        end
        #1 rst_n = 1'b1;
        run_chk = 1;
        idle(2);
        xfer(0, 0, 16'h12A5, 8'h00, 0, 0, 0);   // memory read, no waits
        idle(1);
        xfer(1, 1, 16'h00F3, 8'h5C, 2, 0, 0);   // I/O write, two waits (R7)
        xfer(0, 1, 16'hFF00, 8'h00, 1, 0, 0);   // I/O read, one wait
        xfer(1, 0, 16'hBEEF, 8'hA7, 3, 0, 0);   // memory write, three waits
        // R10: hold raised during a transfer
        xfer(0, 0, 16'h4321, 8'h00, 1, 1, 0);
        idle(3);
        bus_hold = 1'b0;
        idle(2);
        // R9/R11: hold in idle with a request pending
        bus_hold = 1'b1;
        idle(1);
        xfer(1, 0, 16'h8001, 8'h3C, 0, 0, 4);
        idle(3);
        summary();
    end

endmodule